// File: doc/BRIEF.md
# Multi-Latency Issue Interlock

This block sits at the decode stage of an in-order pipeline whose execute stage offers four units with different depths: a one-cycle integer ALU, a seven-stage pipelined multiplier, a four-stage pipelined floating-point adder and a 24-cycle divider that is not pipelined. Each cycle it is offered one decoded instruction, made of a unit class, a destination register and two source registers. It accepts the instruction only when every operand can be forwarded in time, and sends it down exactly one unit lane.

A per-register countdown table records how many more cycles each pending result needs. An instruction is held in decode while any of the following is true:

- a source register still has a nonzero count;
- its destination register still has a nonzero count;
- it is a divide and the divider is still occupied.

Each unit is modelled as a timed delay line that carries the destination tag. Each lane reports on its own writeback pulse in the cycle the unit finishes. Results can therefore retire out of order while issue stays in program order. No arithmetic is performed.

Top module: `mc_issue_top`

## Requirements
- R1: The class code selects the lane: 0 integer ALU, 1 multiplier, 2 floating-point adder, 3 divider. Each accepted instruction produces exactly one writeback pulse, on `wbValid[class]`. Its destination appears on `wbTag[class*5 +: 5]`.
- R2: The writeback pulse appears D cycles after the accept cycle, where D is the unit depth: ALU 1, adder 4, multiplier 7, divider 24.
- R3: A consumer of an ALU result is accepted in the cycle right after its producer, with zero stall cycles.
- R4: A consumer of an adder result stalls exactly 3 cycles.
- R5: A consumer of a multiplier result stalls exactly 6 cycles.
- R6: A consumer of a divider result stalls exactly 23 cycles.
- R7: A divide that follows an accepted divide stalls exactly 23 cycles, even with no register dependency. This keeps the divider holding only one operation at a time.
- R8: Register 0 never causes a stall, whether it is used as a source or as a destination.
- R9: `stall` is high only while `inValid` is high and a hazard exists. `accept` equals `inValid` and not `stall`. No writeback follows a cycle without accept.
- R10: Independent instructions are accepted back to back. A short-latency instruction that follows a long-latency one completes first.
- R11: An instruction whose destination has a pending result stalls until that count reaches zero. With a multiplier producer this takes 6 cycles.
- R12: During and right after reset, `stall` and all `wbValid` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Decoded instruction present |
| inClass | input | 2 | Unit class code (see R1) |
| inDst | input | 5 | Destination register |
| inSrcA | input | 5 | First source register |
| inSrcB | input | 5 | Second source register |
| stall | output | 1 | Instruction held in decode |
| accept | output | 1 | Instruction issued this cycle |
| wbValid | output | 4 | Per-lane completion pulse |
| wbTag | output | 20 | Per-lane destination tag, 5 bits per lane |

## Verification
Issue of a new instruction and completion of an older one on another lane often fall in the same cycle. Two lanes can also complete together, for example a multiplier issued three cycles before an adder. A random in-order stream mixing all four classes over a small register set provokes these collisions. Explicit back-to-back sequences provoke them as well. A behavioural model compares `stall`, `accept` and every lane's pulse and tag on each clock. Dedicated producer-consumer pairs measure the stall count for each unit class against its expected latency.

// File: rtl/mc_issue_pkg.sv
package mc_issue_pkg;
  typedef enum logic [1:0] {
    UNIT_ALU  = 2'd0,
    UNIT_MUL  = 2'd1,
    UNIT_FADD = 2'd2,
    UNIT_DIV  = 2'd3
  } unitE;

  localparam int NUM_UNITS = 4;

  typedef struct packed {
    logic                 go;
    logic [NUM_UNITS-1:0] laneSel;
  } issueStbT;
endpackage

// File: rtl/mc_delay_line.sv
module mc_delay_line #(
  parameter int DEPTH  = 4,
  parameter int W      = 5,
  parameter bit SINGLE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inV,
  input  logic [W-1:0] inTag,
  output logic         outV,
  output logic [W-1:0] outTag
);
  logic [DEPTH-1:0] vPipe;
  logic [W-1:0]     tPipe [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vPipe <= '0;
      for (int i = 0; i < DEPTH; i++) tPipe[i] <= '0;
    end else begin
      vPipe[0] <= inV;
      tPipe[0] <= inTag;
      for (int i = 1; i < DEPTH; i++) begin
        vPipe[i] <= vPipe[i-1];
        tPipe[i] <= tPipe[i-1];
      end
    end
  end

  assign outV   = vPipe[DEPTH-1];
  assign outTag = tPipe[DEPTH-1];

  AST_UNPIPELINED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!SINGLE) || ($countones(vPipe) <= 1)); // R7
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_issue_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int ALU_D  = 1,
  parameter int MUL_D  = 7,
  parameter int ADD_D  = 4,
  parameter int DIV_D  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  unitE              inClass,
  input  logic [REG_AW-1:0] inDst,
  input  logic [REG_AW-1:0] inSrcA,
  input  logic [REG_AW-1:0] inSrcB,
  output logic              stall,
  output issueStbT          stb
);
  localparam int NREG  = 1 << REG_AW;
  localparam int MAX_A = (MUL_D > ADD_D) ? MUL_D : ADD_D;
  localparam int MAX_B = (DIV_D > ALU_D) ? DIV_D : ALU_D;
  localparam int MAXD  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXD + 1);

  logic [CW-1:0] readyCnt [NREG];
  logic [CW-1:0] divCnt;
  logic srcABusy, srcBBusy, dstBusy, divBlock;

  function automatic logic [CW-1:0] waitFor(unitE u);
    case (u)
      UNIT_MUL:  return CW'(MUL_D - 1);
      UNIT_FADD: return CW'(ADD_D - 1);
      UNIT_DIV:  return CW'(DIV_D - 1);
      default:   return CW'(ALU_D - 1);
    endcase
  endfunction

  always_comb begin
    srcABusy    = (inSrcA != '0) && (readyCnt[inSrcA] != '0);
    srcBBusy    = (inSrcB != '0) && (readyCnt[inSrcB] != '0);
    dstBusy     = (inDst  != '0) && (readyCnt[inDst]  != '0);
    divBlock    = (inClass == UNIT_DIV) && (divCnt != '0);
    stall       = inValid && (srcABusy || srcBBusy || dstBusy || divBlock);
    stb.go      = inValid && !stall;
    stb.laneSel = stb.go ? (NUM_UNITS'(1) << inClass) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) readyCnt[r] <= '0;
      divCnt <= '0;
    end else begin
      for (int r = 1; r < NREG; r++) begin
        if (stb.go && inDst == REG_AW'(r)) readyCnt[r] <= waitFor(inClass);
        else if (readyCnt[r] != '0)        readyCnt[r] <= readyCnt[r] - CW'(1);
      end
      readyCnt[0] <= '0;
      if (stb.go && inClass == UNIT_DIV) divCnt <= waitFor(UNIT_DIV);
      else if (divCnt != '0)             divCnt <= divCnt - CW'(1);
    end
  end

  AST_DIV_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (divCnt != '0) |=> (divCnt == $past(divCnt) - CW'(1))); // R7

  AST_ZERO_REG_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inClass != UNIT_DIV && inSrcA == '0 && inSrcB == '0 && inDst == '0)
      |-> !stall); // R8
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_issue_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int ALU_D  = 1,
  parameter int MUL_D  = 7,
  parameter int ADD_D  = 4,
  parameter int DIV_D  = 24
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  issueStbT                       stb,
  input  logic [REG_AW-1:0]              inDst,
  output logic [NUM_UNITS-1:0]           wbValid,
  output logic [NUM_UNITS*REG_AW-1:0]    wbTag
);
  function automatic int laneDepth(int g);
    case (g)
      1:       return MUL_D;
      2:       return ADD_D;
      3:       return DIV_D;
      default: return ALU_D;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_UNITS; g++) begin : gLane
    localparam int D = laneDepth(g);
    mc_delay_line #(
      .DEPTH (D),
      .W     (REG_AW),
      .SINGLE(g == int'(UNIT_DIV))
    ) i_line (
      .clk   (clk),
      .rst_n (rst_n),
      .inV   (stb.laneSel[g]),
      .inTag (inDst),
      .outV  (wbValid[g]),
      .outTag(wbTag[g*REG_AW +: REG_AW])
    );
  end

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    stb.go |-> $onehot(stb.laneSel)); // R1

  AST_IDLE_NO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.go |-> (stb.laneSel == '0)); // R9

  AST_ALU_NEXT_WB: assert property (@(posedge clk) disable iff (!rst_n)
    stb.laneSel[UNIT_ALU] |=> (wbValid[UNIT_ALU] && wbTag[REG_AW-1:0] == $past(inDst))); // R2
endmodule

// File: rtl/mc_issue_top.sv
module mc_issue_top
  import mc_issue_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int ALU_D  = 1,
  parameter int MUL_D  = 7,
  parameter int ADD_D  = 4,
  parameter int DIV_D  = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inValid,
  input  logic [1:0]                  inClass,
  input  logic [REG_AW-1:0]           inDst,
  input  logic [REG_AW-1:0]           inSrcA,
  input  logic [REG_AW-1:0]           inSrcB,
  output logic                        stall,
  output logic                        accept,
  output logic [NUM_UNITS-1:0]        wbValid,
  output logic [NUM_UNITS*REG_AW-1:0] wbTag
);
  issueStbT stb;

  mc_ctrl #(.REG_AW(REG_AW), .ALU_D(ALU_D), .MUL_D(MUL_D), .ADD_D(ADD_D), .DIV_D(DIV_D)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inClass(unitE'(inClass)),
    .inDst(inDst), .inSrcA(inSrcA), .inSrcB(inSrcB), .stall(stall), .stb(stb)
  );

  mc_datapath #(.REG_AW(REG_AW), .ALU_D(ALU_D), .MUL_D(MUL_D), .ADD_D(ADD_D), .DIV_D(DIV_D)) i_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .inDst(inDst), .wbValid(wbValid), .wbTag(wbTag)
  );

  assign accept = stb.go;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wbValid == '0)); // R12
endmodule

// File: tb/test_mc_issue_top.sv
module test_mc_issue_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  inClass = '0;
  logic [4:0]  inDst = '0, inSrcA = '0, inSrcB = '0;
  logic        stall, accept;
  logic [3:0]  wbValid;
  logic [19:0] wbTag;

  int total = 0, bad = 0, cyc = 0, clkCount = 0;
  int regFree [32];
  int divFree = 0;
  int dueTag [int];
  string curReq = "R12";
  bit done = 1'b0;

  always #5 clk = ~clk;

  mc_issue_top i_mc_issue_top (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inClass(inClass), .inDst(inDst),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .stall(stall), .accept(accept),
    .wbValid(wbValid), .wbTag(wbTag)
  );

  function automatic int depthOf(int cls);
    case (cls)
      1: return 7;
      2: return 4;
      3: return 24;
      default: return 1;
    endcase
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", curReq, what, act, exp);
    end
  endtask

  task automatic tick(input bit v, input int cls, input int dst, input int a, input int b,
                      output bit acc);
    bit expStall;
    @(negedge clk);
    inValid = v; inClass = cls[1:0]; inDst = dst[4:0]; inSrcA = a[4:0]; inSrcB = b[4:0];
    #1;
    expStall = v && ((a != 0 && cyc < regFree[a]) || (b != 0 && cyc < regFree[b]) ||
                     (dst != 0 && cyc < regFree[dst]) || (cls == 3 && cyc < divFree));
    check(stall === expStall, "stall", int'(stall), int'(expStall));
    check(accept === (v && !expStall), "accept", int'(accept), int'(v && !expStall));
    for (int l = 0; l < 4; l++) begin
      bit ev = dueTag.exists(cyc * 4 + l);
      check(wbValid[l] === ev, $sformatf("R1 R2 wbValid lane %0d", l), int'(wbValid[l]), int'(ev));
      if (ev && wbValid[l] === 1'b1)
        check(wbTag[l*5 +: 5] == dueTag[cyc * 4 + l][4:0], $sformatf("R1 wbTag lane %0d", l),
              int'(wbTag[l*5 +: 5]), dueTag[cyc * 4 + l]);
    end
    acc = v && !expStall;
    if (acc) begin
      if (dst != 0) regFree[dst] = cyc + depthOf(cls);
      if (cls == 3) divFree = cyc + 24;
      dueTag[(cyc + depthOf(cls)) * 4 + cls] = dst;
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) tick(1'b0, 0, 0, 0, 0, acc);
  endtask

  task automatic depPair(input int pCls, input int pDst, input int cCls, input int cDst,
                         input int cA, input int cB, input int expStalls);
    bit acc;
    int n = 0;
    tick(1'b1, pCls, pDst, 0, 0, acc);
    check(acc, "producer accept", int'(acc), 1);
    forever begin
      tick(1'b1, cCls, cDst, cA, cB, acc);
      if (acc || n > 60) break;
      n++;
    end
    check(n == expStalls, "stall cycles for pair", n, expStalls);
    idle(30);
  endtask

  initial begin
    bit acc;
    for (int r = 0; r < 32; r++) regFree[r] = 0;
    repeat (3) @(negedge clk);
    #1;
    check(stall === 1'b0, "stall in reset", int'(stall), 0);          // R12
    check(wbValid === 4'b0, "wbValid in reset", int'(wbValid), 0);    // R12
    rst_n = 1'b1;
    idle(3);

    curReq = "R3";  depPair(0, 5, 0, 6, 5, 0, 0);
    curReq = "R4";  depPair(2, 5, 0, 6, 5, 0, 3);
    curReq = "R5";  depPair(1, 5, 0, 6, 0, 5, 6);
    curReq = "R6";  depPair(3, 8, 0, 9, 0, 8, 23);
    curReq = "R7";  depPair(3, 1, 3, 2, 10, 11, 23);
    curReq = "R8";  depPair(1, 0, 0, 4, 0, 0, 0);
    curReq = "R11"; depPair(1, 7, 0, 7, 0, 0, 6);

    curReq = "R9";
    tick(1'b1, 1, 12, 0, 0, acc);
    for (int i = 0; i < 4; i++) tick(1'b0, 0, 13, 12, 12, acc);
    idle(10);

    curReq = "R10";
    tick(1'b1, 1, 3, 0, 0, acc);
    tick(1'b1, 0, 4, 0, 0, acc);
    check(acc, "ALU accepted back to back", int'(acc), 1);
    tick(1'b1, 2, 5, 0, 0, acc);
    tick(1'b1, 3, 6, 0, 0, acc);
    idle(30);

    curReq = "R1 R2";
    begin
      int pc = 0, pd = 0, pa = 0, pb = 0;
      bit have = 1'b0;
      for (int i = 0; i < 1500; i++) begin
        if (!have) begin
          have = ($urandom % 4) != 0;
          pc = $urandom % 4;
          if (pc == 3 && ($urandom % 3) != 0) pc = $urandom % 3;
          pd = $urandom % 8; pa = $urandom % 8; pb = $urandom % 8;
        end
        tick(have, pc, pd, pa, pb, acc);
        if (acc) have = 1'b0;
      end
    end
    idle(30);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    clkCount++;
    if (clkCount > 150000 && !done) begin
      done = 1'b1;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", clkCount, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule